// File: doc/BRIEF.md
# Disk Controller Timing and Interrupt Register Block

This block is a small 32-bit register slice that sits next to a disk-interface controller. It occupies a 4 KB window. Address bits [11:4] select one of 256 register slots, so slots are 16 bytes apart. Three slots are live:

- **Slot 0x00** is the drive data port. Writes and reads here pass straight through to an external data interface.
- **Slot 0x20** is a timing word that software owns. The block stores it and returns it unchanged.
- **Slot 0x30** is an interrupt state word.

Every other slot reads as all ones, and writes to those slots do nothing.

All accesses are full 32-bit words. Data is byte-reversed between the bus and the register side, in both directions. The interrupt state word holds two kinds of bit:

- The DMA bit is set by a rising edge of the DMA interrupt input. It stays set until software writes a one to clear it.
- The disk bit is a live copy of the disk interrupt input level.

Both interrupt inputs are also passed straight through, unchanged, to their own output lines. The bus is a plain synchronous request port. Read data appears on `bus_rdata` one clock after the read request and then holds until the next read.

Top module: `drvctl_regs`

## Requirements
- R1: The slot is selected by address bits [11:4] only. Bits [3:0] and any bits above bit 11 have no effect, so addresses that differ only in those bits reach the same slot.
- R2: A write to slot 0x00 drives `dp_wr_en` high in the same cycle. In that cycle `dp_wr_data` equals `bus_wdata` with its four bytes reversed (bus byte 0 becomes bits [31:24]).
- R3: A read of slot 0x00 drives `dp_rd_en` high in the same cycle. On the next cycle `bus_rdata` equals `dp_rd_data` with its bytes reversed.
- R4: A read of slot 0x20 returns exactly the bus value last written to slot 0x20. After reset, the timing word is zero.
- R5: A read of slot 0x30 returns the DMA bit on bus bit 7 and the disk bit on bus bit 6. These are register bits 31 and 30 after the byte reversal. All other bits read as zero.
- R6: A rising edge on `dma_irq_in` sets the DMA bit. The bit stays set while the input stays high and after the input falls. A level that is already high never sets it again.
- R7: A write to slot 0x30 with bus bit 7 set clears the DMA bit. Writes to slot 0x30 with bus bit 7 clear have no effect, whatever their other bits hold.
- R8: If a DMA rising edge and a clear write fall in the same cycle, the DMA bit ends up set.
- R9: The disk bit reads 1 while `disk_irq_in` is high and 0 while it is low. It latches nothing.
- R10: A read of any unmapped slot returns 0xFFFFFFFF. A write to any unmapped slot changes no stored state.
- R11: `dma_irq_out` follows `dma_irq_in` and `disk_irq_out` follows `disk_irq_in` in the same cycle.
- R12: During and after reset, `bus_rdata` is zero, the DMA bit is zero, and both data-port strobes are low when no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_vld | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data, bus byte order |
| bus_rdata | output | 32 | Read data, valid one cycle after the read |
| dp_wr_en | output | 1 | Data-port write strobe |
| dp_wr_data | output | 32 | Data-port write word, byte-reversed |
| dp_rd_en | output | 1 | Data-port read strobe |
| dp_rd_data | input | 32 | Data-port read word, returned in the strobe cycle |
| dma_irq_in | input | 1 | DMA engine interrupt level |
| disk_irq_in | input | 1 | Disk interrupt level |
| dma_irq_out | output | 1 | DMA interrupt passed through |
| disk_irq_out | output | 1 | Disk interrupt passed through |

## Verification
The bench builds the block with `ADDR_W` set to 16 instead of the default 12. This gives the bus address bits above the 4 KB window, so the bench can hit the same slot through addresses in a second window (for example 0x1204 for slot 0x20) and show that those bits are ignored. The stimulus bytes are all distinct, so a byte reversal done in the wrong order or skipped cannot go unnoticed. The interrupt sequences place a DMA rising edge and a clear in the same cycle, and also hold the DMA input high across a clear.

// File: rtl/drvctl_pkg.sv
package drvctl_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned SLOT_W   = 8;
  localparam int unsigned SLOT_LSB = 4;

  localparam logic [SLOT_W-1:0] SLOT_DPORT  = 8'h00;
  localparam logic [SLOT_W-1:0] SLOT_TIMING = 8'h20;
  localparam logic [SLOT_W-1:0] SLOT_ISTAT  = 8'h30;

  // register-domain bit positions (decoded by software after byte reversal)
  localparam int unsigned BIT_DMA  = 31;
  localparam int unsigned BIT_DISK = 30;

  typedef enum logic [1:0] {
    SEL_DPORT  = 2'd0,
    SEL_TIMING = 2'd1,
    SEL_ISTAT  = 2'd2,
    SEL_NONE   = 2'd3
  } slot_sel_e;
endpackage

// File: rtl/drvctl_bswap.sv
module drvctl_bswap #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int unsigned NBYTES = W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign dout[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
  end
endmodule

// File: rtl/drvctl_decode.sv
module drvctl_decode
  import drvctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output slot_sel_e         sel
);
  localparam int unsigned SLOT_MSB = SLOT_LSB + SLOT_W - 1;

  logic [SLOT_W-1:0] slot;
  assign slot = addr[SLOT_MSB:SLOT_LSB];

  if (ADDR_W > SLOT_MSB + 1) begin : g_hi
    logic unused_addr_bits;
    assign unused_addr_bits = ^{addr[ADDR_W-1:SLOT_MSB+1], addr[SLOT_LSB-1:0]};
  end else begin : g_nohi
    logic unused_addr_bits;
    assign unused_addr_bits = ^addr[SLOT_LSB-1:0];
  end

  always_comb begin
    case (slot)
      SLOT_DPORT:  sel = SEL_DPORT;
      SLOT_TIMING: sel = SEL_TIMING;
      SLOT_ISTAT:  sel = SEL_ISTAT;
      default:     sel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/drvctl_irqstat.sv
module drvctl_irqstat (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_lvl,
  input  logic clr_req,
  output logic dma_lat
);
  logic dma_prev_q, dma_prev_d;
  logic lat_q, lat_d;
  logic rise;

  assign rise = dma_lvl & ~dma_prev_q;

  always_comb begin
    dma_prev_d = dma_lvl;
    lat_d      = lat_q;
    if (clr_req) lat_d = 1'b0;
    if (rise)    lat_d = 1'b1;   // set has priority over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_prev_q <= 1'b0;
      lat_q      <= 1'b0;
    end else begin
      dma_prev_q <= dma_prev_d;
      lat_q      <= lat_d;
    end
  end

  assign dma_lat = lat_q;
endmodule

// File: rtl/drvctl_regs.sv
module drvctl_regs
  import drvctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dp_wr_en,
  output logic [31:0]       dp_wr_data,
  output logic              dp_rd_en,
  input  logic [31:0]       dp_rd_data,
  input  logic              dma_irq_in,
  input  logic              disk_irq_in,
  output logic              dma_irq_out,
  output logic              disk_irq_out
);
  slot_sel_e         sel;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rd_bus;
  logic [WORD_W-1:0] timing_q, timing_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              timing_en, rdata_en;
  logic              wr_req, rd_req, clr_req;
  logic              dma_lat;

  drvctl_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(bus_addr), .sel(sel));
  drvctl_bswap  #(.W(WORD_W)) u_wswap (.din(bus_wdata), .dout(wr_word));
  drvctl_bswap  #(.W(WORD_W)) u_rswap (.din(rd_word),   .dout(rd_bus));

  assign wr_req  = bus_vld &  bus_wr;
  assign rd_req  = bus_vld & ~bus_wr;
  assign clr_req = wr_req & (sel == SEL_ISTAT) & wr_word[BIT_DMA];

  drvctl_irqstat u_istat (
    .clk    (clk),
    .rst_n  (rst_n),
    .dma_lvl(dma_irq_in),
    .clr_req(clr_req),
    .dma_lat(dma_lat)
  );

  assign dp_wr_en   = wr_req & (sel == SEL_DPORT);
  assign dp_wr_data = wr_word;
  assign dp_rd_en   = rd_req & (sel == SEL_DPORT);

  always_comb begin
    rd_word = '1;
    case (sel)
      SEL_DPORT:  rd_word = dp_rd_data;
      SEL_TIMING: rd_word = timing_q;
      SEL_ISTAT: begin
        rd_word           = '0;
        rd_word[BIT_DMA]  = dma_lat;
        rd_word[BIT_DISK] = disk_irq_in;
      end
      default:    rd_word = '1;
    endcase
  end

  assign timing_en = wr_req & (sel == SEL_TIMING);
  assign timing_d  = wr_word;
  assign rdata_en  = rd_req;
  assign rdata_d   = rd_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      rdata_q  <= '0;
    end else begin
      if (timing_en) timing_q <= timing_d;
      if (rdata_en)  rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign dma_irq_out  = dma_irq_in;
  assign disk_irq_out = disk_irq_in;
endmodule

// File: rtl/drvctl_regs_chk.sv
module drvctl_regs_chk
  import drvctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_vld,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              dp_wr_en,
  input logic              dma_irq_in,
  input logic              dma_lat
);
  logic [7:0] slot;
  logic       clr_wr, unmapped_rd, edge_seen;
  logic       prev_in;

  assign slot        = bus_addr[11:4];
  assign clr_wr      = bus_vld & bus_wr & (slot == SLOT_ISTAT) & bus_wdata[7];
  assign unmapped_rd = bus_vld & ~bus_wr & (slot != SLOT_DPORT) &
                       (slot != SLOT_TIMING) & (slot != SLOT_ISTAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_in <= 1'b0;
    else        prev_in <= dma_irq_in;
  end
  assign edge_seen = dma_irq_in & ~prev_in;

  assert_dpwr_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dp_wr_en |-> (bus_vld && bus_wr && slot == SLOT_DPORT));

  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_seen |=> dma_lat);

  assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_lat && !edge_seen) |=> !dma_lat);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !edge_seen) |=> !dma_lat);

  assert_hold_without_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_lat && !clr_wr) |=> dma_lat);

  assert_unmapped_ones_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> (bus_rdata == 32'hFFFF_FFFF));
endmodule

bind drvctl_regs drvctl_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_vld   (bus_vld),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .dp_wr_en  (dp_wr_en),
  .dma_irq_in(dma_irq_in),
  .dma_lat   (dma_lat)
);

// File: tb/drvctl_regs_bench.sv
module drvctl_regs_bench;
  localparam int unsigned AW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_vld, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          dp_wr_en, dp_rd_en;
  logic [31:0]   dp_wr_data, dp_rd_data;
  logic          dma_irq_in, disk_irq_in, dma_irq_out, disk_irq_out;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  drvctl_regs #(.ADDR_W(AW)) u_drvctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dp_wr_en(dp_wr_en), .dp_wr_data(dp_wr_data), .dp_rd_en(dp_rd_en),
    .dp_rd_data(dp_rd_data), .dma_irq_in(dma_irq_in), .disk_irq_in(disk_irq_in),
    .dma_irq_out(dma_irq_out), .disk_irq_out(disk_irq_out)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic        wr;
    logic [15:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [7:0]  req;    // requirement number for the message
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 16'h0200, 32'h1122_3344, 8'd4},
    '{1'b0, 16'h0200, 32'h1122_3344, 8'd4},
    '{1'b0, 16'h1204, 32'h1122_3344, 8'd1},
    '{1'b0, 16'h0100, 32'hFFFF_FFFF, 8'd10},
    '{1'b1, 16'h0400, 32'h0000_0000, 8'd10},
    '{1'b0, 16'h020C, 32'h1122_3344, 8'd10},
    '{1'b1, 16'h1208, 32'hA5C3_0F81, 8'd1},
    '{1'b0, 16'h0200, 32'hA5C3_0F81, 8'd1}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    @(negedge clk);
    bus_vld = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_vld = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog got %0d exp <20000", cycles);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; bus_vld = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    dp_rd_data = 32'h0A0B_0C0D; dma_irq_in = 1'b0; disk_irq_in = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R12 rdata in reset", bus_rdata, 32'h0);
    check("R12 strobes in reset", {30'b0, dp_wr_en, dp_rd_en}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R12 rdata after reset", bus_rdata, 32'h0);
    bus_read(16'h0300, rd); check("R12 dma bit after reset", rd, 32'h0);
    bus_read(16'h0200, rd); check("R4 timing reset value", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) bus_write(TBL[i].addr, TBL[i].data);
      else begin
        bus_read(TBL[i].addr, rd);
        check($sformatf("R%0d table[%0d]", TBL[i].req, i), rd, TBL[i].data);
      end
    end

    // R2: data port write, byte reversed, same cycle
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = 16'h0004; bus_wdata = 32'hDEAD_BEEF;
    #1;
    check("R2 dp_wr_en", {31'b0, dp_wr_en}, 32'h1);
    check("R2 dp_wr_data", dp_wr_data, 32'hEFBE_ADDE);
    @(negedge clk); bus_vld = 1'b0; bus_wr = 1'b0;
    #1; check("R2 dp_wr_en idle", {31'b0, dp_wr_en}, 32'h0);

    // R3: data port read
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = 16'h0000;
    #1; check("R3 dp_rd_en", {31'b0, dp_rd_en}, 32'h1);
    @(posedge clk); #1;
    check("R3 dp read data", bus_rdata, 32'h0D0C_0B0A);
    @(negedge clk); bus_vld = 1'b0;

    // R9/R5/R11: disk level
    @(negedge clk); disk_irq_in = 1'b1;
    #1; check("R11 disk pass", {31'b0, disk_irq_out}, 32'h1);
    bus_read(16'h0300, rd); check("R9 disk high (R5 bit 6)", rd, 32'h0000_0040);
    @(negedge clk); disk_irq_in = 1'b0;
    bus_read(16'h0300, rd); check("R9 disk low", rd, 32'h0);

    // R6: rising edge latches, sticky after fall
    @(negedge clk); dma_irq_in = 1'b1;
    #1; check("R11 dma pass", {31'b0, dma_irq_out}, 32'h1);
    bus_read(16'h0300, rd); check("R6 dma latched (R5 bit 7)", rd, 32'h0000_0080);
    @(negedge clk); dma_irq_in = 1'b0;
    bus_read(16'h0300, rd); check("R6 sticky after fall", rd, 32'h0000_0080);

    // R7: write without bit 7 ignored, then clear
    bus_write(16'h0300, 32'hFFFF_FF7F);
    bus_read(16'h0300, rd); check("R7 no-clear write ignored", rd, 32'h0000_0080);
    bus_write(16'h0300, 32'h0000_0080);
    bus_read(16'h0300, rd); check("R7 clear", rd, 32'h0);

    // R8: edge and clear in the same cycle
    @(negedge clk);
    dma_irq_in = 1'b1;
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = 16'h0300; bus_wdata = 32'h0000_0080;
    @(negedge clk); bus_vld = 1'b0; bus_wr = 1'b0;
    bus_read(16'h0300, rd); check("R8 set wins", rd, 32'h0000_0080);

    // R6: held high level does not set again after clear
    bus_write(16'h0300, 32'h0000_0080);
    repeat (2) @(posedge clk);
    bus_read(16'h0300, rd); check("R6 high level no re-set", rd, 32'h0);
    @(negedge clk); dma_irq_in = 1'b0;

    // R10: unmapped write left timing intact (aliased read, R1)
    bus_write(16'h0F00, 32'h0);
    bus_read(16'h1200, rd); check("R10 unmapped write ignored", rd, 32'hA5C3_0F81);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule